// File: doc/BRIEF.md
# Interruptible Memory Block Copy Engine

This block moves a run of bytes from one region of a 24-bit byte-addressed memory to another, one byte at a time, through a single memory port with separate read and write strobes. Software-visible state is three 16-bit registers and two bank bytes. The X register indexes the source and the Y register the destination. The count register holds the length minus one. The source bank and destination bank supply the upper eight address bits of every read and every write respectively. A command byte selects the direction. 0x54 walks both blocks upward from their first bytes. 0x44 walks both blocks downward from their last bytes.

Each byte costs a fixed seven-cycle slot: a read strobe, a capture of the returned data, a write strobe, idle bookkeeping, and finally an update of X, Y and the count. The copy ends when the count steps from zero to 0xFFFF. An interrupt request is only acted on at the end of a slot, so the byte in flight always lands first. The engine then parks with X, Y and the count describing exactly the work left. A later resume picks up from those registers without reloading anything. A narrow-index input confines both indices to their low byte, so that all traffic stays inside the bottom 256 bytes of each bank.

Top module: `blkcpy_engine`

## Requirements
- R1: A start pulse with command 0x54 copies count+1 bytes. Byte k is read from source index X+k and written to destination index Y+k, in increasing order. At completion X and Y are one past the last byte of each block.
- R2: A start pulse with command 0x44 copies count+1 bytes. Byte k is read from X-k and written to Y-k. At completion X and Y are one before the first byte of each block.
- R3: On completion busy drops, done rises and the count reads 0xFFFF. Done stays high until a new start is accepted.
- R4: The read strobe for byte k is high for exactly one cycle, in the cycle 7k after the start edge. Busy falls 7N cycles after the start edge for an N-byte copy.
- R5: The read data is taken in the cycle after the read strobe. It is written out with the write strobe two cycles after that byte's read strobe. The read and write strobes are never high together.
- R6: Address bits 23:16 carry the source bank byte on reads and the destination bank byte on writes.
- R7: An interrupt request seen during a byte's slot lets that byte finish. The engine then stops with busy and done both low, and X, Y and count advanced by exactly the bytes moved. If that byte was the last one, the copy simply completes.
- R8: A resume pulse while paused continues from the stored registers. The combined transfer, including its address sequence and timing, matches an uninterrupted copy.
- R9: While the narrow-index input is high, address bits 15:8 are zero. The index registers load and step with their upper byte forced to zero, and the low byte wraps within 0..255.
- R10: A start pulse while busy is ignored. A start pulse whose command is neither 0x54 nor 0x44 is ignored: no strobe, and no register change.
- R11: A resume pulse when the engine is not paused is ignored.
- R12: After reset busy, done, both strobes, X, Y and count are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load registers from the ld_* inputs and begin a copy |
| resume | input | 1 | Continue a paused copy from the current registers |
| irq | input | 1 | Interrupt request; pause at the end of the current byte |
| narrow | input | 1 | Confine indices to their low byte |
| cmd_op | input | 8 | Command byte: 0x54 ascending, 0x44 descending |
| cmd_src_bank | input | 8 | Source bank byte, loaded on start |
| cmd_dst_bank | input | 8 | Destination bank byte, loaded on start |
| ld_x | input | 16 | Source index loaded on start |
| ld_y | input | 16 | Destination index loaded on start |
| ld_cnt | input | 16 | Length minus one loaded on start |
| mem_addr | output | 24 | Memory byte address |
| mem_rd | output | 1 | Read strobe; data returns the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd |
| x_o | output | 16 | Live source index |
| y_o | output | 16 | Live destination index |
| cnt_o | output | 16 | Live count |
| busy | output | 1 | Copy in progress |
| done | output | 1 | Last copy completed |

## Verification
A wrong phase counter or a corrupted index shows on the very next read strobe of the copy. Each strobe is checked against the cycle it should fall in and the address it should carry, so a fault appears within seven cycles rather than only in the final memory image. A stale interrupt latch or a count that stops too early or too late shows when busy falls, as a wrong fall cycle, a wrong done level, or X, Y and count that disagree with the bytes actually seen on the port. Interrupt pulses swept across every cycle offset of a short copy expose any slot in which the pause decision is taken at the wrong moment.

// File: rtl/blkcpy_pkg.sv
package blkcpy_pkg;
    localparam int IDX_W  = 16;
    localparam int BANK_W = 8;
    localparam int DATA_W = 8;
    localparam int ADDR_W = BANK_W + IDX_W;
    localparam int LOW_W  = 8;

    localparam logic [7:0] OP_UP   = 8'h54;
    localparam logic [7:0] OP_DOWN = 8'h44;

    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_PAUSED, ST_DONE} seq_state_e;
    typedef enum logic {DIR_UP, DIR_DOWN} dir_e;

    typedef struct packed {
        dir_e              dir;
        logic [BANK_W-1:0] src_bank;
        logic [BANK_W-1:0] dst_bank;
    } cmd_t;

    function automatic logic [IDX_W-1:0] fold_idx(input logic [IDX_W-1:0] v,
                                                  input logic nar);
        return nar ? {{(IDX_W-LOW_W){1'b0}}, v[LOW_W-1:0]} : v;
    endfunction

    function automatic logic [IDX_W-1:0] step_idx(input logic [IDX_W-1:0] v,
                                                  input dir_e d,
                                                  input logic nar);
        logic [IDX_W-1:0] e;
        e = fold_idx(v, nar);
        e = (d == DIR_UP) ? e + 1'b1 : e - 1'b1;
        return fold_idx(e, nar);
    endfunction
endpackage

// File: rtl/blkcpy_seq.sv
module blkcpy_seq
    import blkcpy_pkg::*;
#(
    parameter int CYC = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic op_valid,
    input  logic resume,
    input  logic irq,
    input  logic last_byte,
    output logic busy,
    output logic done,
    output logic load,
    output logic advance,
    output logic rd_phase,
    output logic cap_phase,
    output logic wr_phase
);
    localparam int PW = (CYC > 2) ? $clog2(CYC) : 2;

    seq_state_e    state_q;
    logic [PW-1:0] phase_q;
    logic          irq_q;
    logic          accept_resume;
    logic          go;

    assign load          = start && op_valid && (state_q != ST_RUN);
    assign accept_resume = resume && (state_q == ST_PAUSED) && !load;
    assign go            = load || accept_resume;
    assign busy          = (state_q == ST_RUN);
    assign done          = (state_q == ST_DONE);
    assign advance       = busy && (phase_q == PW'(CYC - 1));
    assign rd_phase      = busy && (phase_q == PW'(0));
    assign cap_phase     = busy && (phase_q == PW'(1));
    assign wr_phase      = busy && (phase_q == PW'(2));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            phase_q <= '0;
            irq_q   <= 1'b0;
        end else if (go) begin
            state_q <= ST_RUN;
            phase_q <= '0;
            irq_q   <= 1'b0;
        end else if (state_q == ST_RUN) begin
            if (advance) begin
                phase_q <= '0;
                irq_q   <= 1'b0;
                if (last_byte)
                    state_q <= ST_DONE;
                else if (irq_q || irq)
                    state_q <= ST_PAUSED;
            end else begin
                phase_q <= phase_q + 1'b1;
                irq_q   <= irq_q | irq;
            end
        end
    end

    // R7
    run_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !advance) |=> busy);

    // R3
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !(start && op_valid)) |=> done);
endmodule

// File: rtl/blkcpy_regs.sv
module blkcpy_regs
    import blkcpy_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              advance,
    input  logic              busy,
    input  logic              narrow,
    input  logic [IDX_W-1:0]  ld_x,
    input  logic [IDX_W-1:0]  ld_y,
    input  logic [IDX_W-1:0]  ld_cnt,
    input  cmd_t              ld_cmd,
    output logic [IDX_W-1:0]  x_q,
    output logic [IDX_W-1:0]  y_q,
    output logic [IDX_W-1:0]  cnt_q,
    output logic              last_byte,
    output logic [ADDR_W-1:0] src_addr,
    output logic [ADDR_W-1:0] dst_addr
);
    cmd_t cmd_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q   <= '0;
            y_q   <= '0;
            cnt_q <= '0;
            cmd_q <= '0;
        end else if (load) begin
            x_q   <= fold_idx(ld_x, narrow);
            y_q   <= fold_idx(ld_y, narrow);
            cnt_q <= ld_cnt;
            cmd_q <= ld_cmd;
        end else if (advance) begin
            x_q   <= step_idx(x_q, cmd_q.dir, narrow);
            y_q   <= step_idx(y_q, cmd_q.dir, narrow);
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign last_byte = (cnt_q == '0);
    assign src_addr  = {cmd_q.src_bank, fold_idx(x_q, narrow)};
    assign dst_addr  = {cmd_q.dst_bank, fold_idx(y_q, narrow)};

    // R10
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !load) |=> ($stable(x_q) && $stable(y_q) && $stable(cnt_q)));
endmodule

// File: rtl/blkcpy_port.sv
module blkcpy_port
    import blkcpy_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_phase,
    input  logic              cap_phase,
    input  logic              wr_phase,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata
);
    logic [DATA_W-1:0] hold_q;

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= '0;
        else if (cap_phase)
            hold_q <= mem_rdata;
    end

    assign mem_rd    = rd_phase;
    assign mem_wr    = wr_phase;
    assign mem_addr  = wr_phase ? dst_addr : src_addr;
    assign mem_wdata = hold_q;

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R5
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> $past(mem_rd, 2));
endmodule

// File: rtl/blkcpy_engine.sv
module blkcpy_engine
    import blkcpy_pkg::*;
#(
    parameter int CYCLES_PER_BYTE = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                resume,
    input  logic                irq,
    input  logic                narrow,
    input  logic [7:0]          cmd_op,
    input  logic [BANK_W-1:0]   cmd_src_bank,
    input  logic [BANK_W-1:0]   cmd_dst_bank,
    input  logic [IDX_W-1:0]    ld_x,
    input  logic [IDX_W-1:0]    ld_y,
    input  logic [IDX_W-1:0]    ld_cnt,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_rd,
    output logic                mem_wr,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic [IDX_W-1:0]    x_o,
    output logic [IDX_W-1:0]    y_o,
    output logic [IDX_W-1:0]    cnt_o,
    output logic                busy,
    output logic                done
);
    logic              op_valid;
    cmd_t              cmd_in;
    logic              load, advance, last_byte;
    logic              rd_phase, cap_phase, wr_phase;
    logic [ADDR_W-1:0] src_addr, dst_addr;

    always_comb begin
        op_valid        = (cmd_op == OP_UP) || (cmd_op == OP_DOWN);
        cmd_in.dir      = (cmd_op == OP_DOWN) ? DIR_DOWN : DIR_UP;
        cmd_in.src_bank = cmd_src_bank;
        cmd_in.dst_bank = cmd_dst_bank;
    end

    blkcpy_seq #(.CYC(CYCLES_PER_BYTE)) seq_i (
        .clk(clk), .rst(rst), .start(start), .op_valid(op_valid),
        .resume(resume), .irq(irq), .last_byte(last_byte),
        .busy(busy), .done(done), .load(load), .advance(advance),
        .rd_phase(rd_phase), .cap_phase(cap_phase), .wr_phase(wr_phase)
    );

    blkcpy_regs regs_i (
        .clk(clk), .rst(rst), .load(load), .advance(advance), .busy(busy),
        .narrow(narrow), .ld_x(ld_x), .ld_y(ld_y), .ld_cnt(ld_cnt),
        .ld_cmd(cmd_in), .x_q(x_o), .y_q(y_o), .cnt_q(cnt_o),
        .last_byte(last_byte), .src_addr(src_addr), .dst_addr(dst_addr)
    );

    blkcpy_port port_i (
        .clk(clk), .rst(rst), .rd_phase(rd_phase), .cap_phase(cap_phase),
        .wr_phase(wr_phase), .src_addr(src_addr), .dst_addr(dst_addr),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata)
    );

    // R3
    done_count_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (cnt_o == {IDX_W{1'b1}}));

    // R9
    narrow_addr_chk: assert property (@(posedge clk) disable iff (rst)
        ((mem_rd || mem_wr) && narrow) |-> (mem_addr[15:8] == 8'h00));
endmodule

// File: tb/blkcpy_engine_tb_top.sv
module blkcpy_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, resume = 1'b0, irq = 1'b0, narrow = 1'b0;
    logic [7:0]  cmd_op = 8'h00, cmd_src_bank = 8'h00, cmd_dst_bank = 8'h00;
    logic [15:0] ld_x = '0, ld_y = '0, ld_cnt = '0;
    logic [23:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = 8'h00;
    logic [15:0] x_o, y_o, cnt_o;
    logic        busy, done;

    int     n_checks = 0;
    int     n_errors = 0;
    longint cyc = 0;
    longint t0 = 0;
    int     k_rd = 0, k_wr = 0;
    bit     run_active = 0;
    bit     e_down = 0, e_nar = 0;
    logic [7:0]  e_sb, e_db;
    logic [15:0] e_x0, e_y0;
    bit     finished = 0;

    logic [7:0] wmem [logic [23:0]];

    always #4 clk = ~clk;   // 125 MHz

    always @(posedge clk) cyc <= cyc + 1;

    blkcpy_engine dut_i (
        .clk(clk), .rst(rst), .start(start), .resume(resume), .irq(irq),
        .narrow(narrow), .cmd_op(cmd_op), .cmd_src_bank(cmd_src_bank),
        .cmd_dst_bank(cmd_dst_bank), .ld_x(ld_x), .ld_y(ld_y), .ld_cnt(ld_cnt),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .x_o(x_o), .y_o(y_o),
        .cnt_o(cnt_o), .busy(busy), .done(done)
    );

    function automatic logic [7:0] pat(input logic [23:0] a);
        return (a[7:0] ^ a[15:8] ^ {a[20:16], a[23:21]}) + 8'h5A;
    endfunction

    function automatic logic [15:0] eidx(input logic [15:0] b, input int k,
                                         input bit down, input bit nar);
        logic [15:0] v;
        v = down ? b - 16'(k) : b + 16'(k);
        if (nar) v = {8'h00, v[7:0]};
        return v;
    endfunction

    always @(posedge clk) begin
        if (mem_rd)
            mem_rdata <= wmem.exists(mem_addr) ? wmem[mem_addr] : pat(mem_addr);
        if (mem_wr)
            wmem[mem_addr] = mem_wdata;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // strobe monitor: address, timing and data of every transfer
    always @(negedge clk) if (!rst) begin
        if (mem_rd) begin
            if (!run_active)
                chk(0, "R10", "read strobe with no accepted command", mem_addr, 0);
            else begin
                chk(cyc == t0 + 7 * k_rd, "R4", "read strobe cycle", cyc, t0 + 7 * k_rd);
                chk(mem_addr[15:0] == eidx(e_x0, k_rd, e_down, e_nar),
                    e_down ? "R2" : "R1", "source index", mem_addr[15:0],
                    eidx(e_x0, k_rd, e_down, e_nar));
                chk(mem_addr[23:16] == e_sb, "R6", "source bank", mem_addr[23:16], e_sb);
            end
            k_rd++;
        end
        if (mem_wr) begin
            if (!run_active)
                chk(0, "R10", "write strobe with no accepted command", mem_addr, 0);
            else begin
                chk(cyc == t0 + 7 * k_wr + 2, "R5", "write strobe cycle", cyc, t0 + 7 * k_wr + 2);
                chk(mem_addr[15:0] == eidx(e_y0, k_wr, e_down, e_nar),
                    e_down ? "R2" : "R1", "destination index", mem_addr[15:0],
                    eidx(e_y0, k_wr, e_down, e_nar));
                chk(mem_addr[23:16] == e_db, "R6", "destination bank", mem_addr[23:16], e_db);
                chk(mem_wdata == pat({e_sb, eidx(e_x0, k_wr, e_down, e_nar)}), "R5",
                    "write data", mem_wdata, pat({e_sb, eidx(e_x0, k_wr, e_down, e_nar)}));
            end
            k_wr++;
        end
    end

    task automatic wait_idle(input int limit);
        for (int i = 0; i < limit && busy; i++) @(negedge clk);
    endtask

    // one copy; irq_off < 0 means no interrupt; poke pulses start mid-run
    task automatic run_copy(input logic [7:0] op, input logic [7:0] sb,
                            input logic [7:0] db, input logic [15:0] x0,
                            input logic [15:0] y0, input int n,
                            input bit nar, input int irq_off, input bit poke);
        int b;
        int moved;
        logic [15:0] xs;
        e_down = (op == 8'h44); e_nar = nar; e_sb = sb; e_db = db;
        e_x0 = nar ? {8'h00, x0[7:0]} : x0;
        e_y0 = nar ? {8'h00, y0[7:0]} : y0;
        @(negedge clk);
        narrow = nar; cmd_op = op; cmd_src_bank = sb; cmd_dst_bank = db;
        ld_x = x0; ld_y = y0; ld_cnt = 16'(n - 1);
        start = 1'b1; t0 = cyc + 1; k_rd = 0; k_wr = 0; run_active = 1;
        @(negedge clk);
        start = 1'b0;
        if (irq_off >= 0)
            fork
                begin
                    while (cyc < t0 + irq_off) @(negedge clk);
                    irq = 1'b1;
                    @(negedge clk);
                    irq = 1'b0;
                end
            join_none
        if (poke)
            fork
                begin
                    while (cyc < t0 + 9) @(negedge clk);
                    start = 1'b1; cmd_op = 8'h54 ^ op ^ 8'h44;
                    ld_x = ~x0; ld_y = ~y0; ld_cnt = 16'h0003;
                    cmd_src_bank = 8'hEE; cmd_dst_bank = 8'hEF;
                    @(negedge clk);
                    start = 1'b0;
                end
            join_none
        b = (irq_off >= 0) ? irq_off / 7 : n;
        if (irq_off >= 0 && b < n - 1) begin
            moved = b + 1;
            wait_idle(7 * n + 20);
            chk(cyc == t0 + 7 * moved, "R7", "pause cycle", cyc, t0 + 7 * moved);
            chk(!done && !busy, "R7", "paused flags", {busy, done}, 0);
            chk(x_o == eidx(e_x0, moved, e_down, nar), "R7", "X at pause",
                x_o, eidx(e_x0, moved, e_down, nar));
            chk(y_o == eidx(e_y0, moved, e_down, nar), "R7", "Y at pause",
                y_o, eidx(e_y0, moved, e_down, nar));
            chk(cnt_o == 16'(n - 1 - moved), "R7", "count at pause", cnt_o, n - 1 - moved);
            xs = x_o;
            repeat (3) @(negedge clk);
            chk(!busy && x_o == xs, "R7", "stays paused", {busy, x_o}, {1'b0, xs});
            resume = 1'b1; t0 = cyc + 1 - 7 * moved;
            @(negedge clk);
            resume = 1'b0;
        end
        wait_idle(7 * n + 20);
        chk(cyc == t0 + 7 * n, "R4", "busy fall cycle", cyc, t0 + 7 * n);
        chk(done && !busy, "R3", "done flags", {busy, done}, 1);
        chk(cnt_o == 16'hFFFF, "R3", "final count", cnt_o, 16'hFFFF);
        chk(x_o == eidx(e_x0, n, e_down, nar), e_down ? "R2" : "R1", "final X",
            x_o, eidx(e_x0, n, e_down, nar));
        chk(y_o == eidx(e_y0, n, e_down, nar), irq_off >= 0 ? "R8" : "R1", "final Y",
            y_o, eidx(e_y0, n, e_down, nar));
        chk(k_rd == n && k_wr == n, "R8", "transfer count", k_rd, n);
        for (int k = 0; k < n; k++) begin
            logic [23:0] da;
            logic [23:0] sa;
            da = {db, eidx(e_y0, k, e_down, nar)};
            sa = {sb, eidx(e_x0, k, e_down, nar)};
            chk(wmem.exists(da) && wmem[da] == pat(sa), "R1", "destination byte",
                wmem.exists(da) ? wmem[da] : 9'h100, pat(sa));
        end
        if (nar) chk(x_o[15:8] == 8'h00 && y_o[15:8] == 8'h00, "R9", "narrow upper bytes",
                     {x_o[15:8], y_o[15:8]}, 0);
        run_active = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] bases [3];
        bases[0] = 16'h0000; bases[1] = 16'h7FFD; bases[2] = 16'hFFFE;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk(!busy && !done && !mem_rd && !mem_wr, "R12", "reset flags",
            {busy, done, mem_rd, mem_wr}, 0);
        chk(x_o == 0 && y_o == 0 && cnt_o == 0, "R12", "reset registers",
            {x_o, y_o, cnt_o}, 0);

        // R11 resume while idle
        resume = 1'b1; @(negedge clk); resume = 1'b0; @(negedge clk);
        chk(!busy && cnt_o == 0, "R11", "resume from idle", {busy, cnt_o}, 0);

        // R1 R2 R6 sweep over direction, length and base
        for (int d = 0; d < 2; d++)
            for (int n = 1; n <= 6; n++)
                for (int bi = 0; bi < 3; bi++)
                    run_copy(d ? 8'h44 : 8'h54, 8'h10 + 8'(bi), 8'h80 + 8'(n),
                             bases[bi], bases[bi] ^ 16'h1234, n, 0, -1, 0);
        run_copy(8'h54, 8'h13, 8'h90, 16'h4000, 16'h5000, 20, 0, -1, 0);

        // R11 resume after completion
        resume = 1'b1; @(negedge clk); resume = 1'b0; @(negedge clk);
        chk(!busy && done && cnt_o == 16'hFFFF, "R11", "resume after done",
            {busy, done, cnt_o}, {1'b0, 1'b1, 16'hFFFF});

        // R7 R8 interrupt at every offset of a five-byte copy, both directions
        for (int d = 0; d < 2; d++)
            for (int off = 0; off < 35; off++)
                run_copy(d ? 8'h44 : 8'h54, 8'h11, 8'hA0 + 8'(off), 16'h2100,
                         16'h3300, 5, 0, off, 0);

        // R9 narrow index wrapping
        run_copy(8'h54, 8'h12, 8'hC0, 16'h12FE, 16'h34FD, 5, 1, -1, 0);
        run_copy(8'h44, 8'h12, 8'hC1, 16'hAB01, 16'hCD02, 5, 1, 12, 0);

        // R10 start while busy
        run_copy(8'h54, 8'h14, 8'hD0, 16'h0100, 16'h0200, 4, 0, -1, 1);
        run_copy(8'h44, 8'h14, 8'hD1, 16'h0100, 16'h0200, 4, 0, -1, 1);

        // R10 unknown command
        begin
            logic [15:0] xs;
            xs = x_o;
            @(negedge clk);
            cmd_op = 8'h55; ld_x = 16'h7777; ld_cnt = 16'h0002; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (3) @(negedge clk);
            chk(!busy && x_o == xs && done, "R10", "unknown command ignored",
                {busy, x_o}, {1'b0, xs});
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule